// File: doc/BRIEF.md
# Programmable Limited-Range Clamp

This block limits each colour component of a pixel stream to a legal range just before the pixels leave the display pipeline. Each pixel carries three components of `CW` bits (12 by default). A registered configuration holds a clamp enable and a 3-bit format code. The code picks one of three behaviours. The first is no clamping, which covers 6-bit output and the reserved codes. The second is a fixed limited range for 8, 10 or 12 bits per component, expressed on the full `CW`-bit scale. The third is a programmable mode in which red, green and blue each have their own lower and upper bound.

A pixel comes in with `in_valid` and leaves one clock later with `out_valid`. A component below its lower bound is replaced by that bound. A component above its upper bound is replaced by that bound. Any other component passes through unchanged. The programmable bounds are written one channel at a time through a small write port. They reset to a lower limit of 0x010 and an upper limit of 0xFEF.

Top module: `pix_range_clamp`

## Requirements
- R1: During and after reset, `out_valid` is 0, the output components are 0, the enable and the format code are cleared (so pixels pass unchanged), and every programmable bound is back at lower 0x010 and upper 0xFEF.
- R2: While the registered enable is 0, every pixel passes unchanged, whatever the format code is.
- R3: Format code 0 (6 bits per component) and the reserved codes 4, 5 and 6 apply no clamping, even when the block is enabled.
- R4: With the block enabled, code 1 clamps each component to 256..3775, code 2 to 256..3763, and code 3 to 256..3760. These are the 8-, 10- and 12-bit ranges 16..235, 64..940 and 256..3760 shifted up to 12 bits, with the upper limit filling the dropped low bits.
- R5: With the block enabled, code 7 clamps red, green and blue each to their own programmable lower and upper bound.
- R6: A pulse on `bnd_wr` loads `bnd_lo` and `bnd_hi` into the channel named by `bnd_ch`, where 0 is red, 1 is green and 2 is blue. Value 3 changes no bound.
- R7: A component below the lower bound becomes the lower bound. A component above the upper bound becomes the upper bound. A component inside the range is unchanged. If the lower bound is greater than the upper bound, the lower-bound test is applied first.
- R8: `out_valid` is `in_valid` delayed by one clock, and the result of a pixel appears in that same cycle. The output components hold their value in any cycle where `in_valid` is 0.
- R9: A configuration write (`cfg_wr`) affects only pixels accepted after the clock edge that stores it. A pixel accepted on that same edge uses the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Stores `cfg_en` and `cfg_fmt` |
| cfg_en | input | 1 | Clamp enable value to store |
| cfg_fmt | input | 3 | Format code to store |
| bnd_wr | input | 1 | Stores bounds for one channel |
| bnd_ch | input | 2 | Channel select for a bound write |
| bnd_lo | input | CW | Lower bound to store |
| bnd_hi | input | CW | Upper bound to store |
| in_valid | input | 1 | Input pixel strobe |
| in_r | input | CW | Red input component |
| in_g | input | CW | Green input component |
| in_b | input | CW | Blue input component |
| out_valid | output | 1 | Output pixel strobe |
| out_r | output | CW | Red output component |
| out_g | output | CW | Green output component |
| out_b | output | CW | Blue output component |

## Verification
The bench builds the block with its default parameters: `CW` = 12 and bounds of 0x010 and 0xFEF. This makes the fixed-range limits for codes 1, 2 and 3 differ only in their upper values 3775, 3763 and 3760, so values placed just outside and just inside each limit can tell the three codes apart. The 12-bit default bounds also put the reset values of the programmable registers directly in view, by clamping 15 up to 16 and 4080 down to 4079.

// File: rtl/rng_clamp_pkg.sv
package rng_clamp_pkg;

    localparam int COMP_W_DEF = 12;

    typedef enum logic [2:0] {
        CF_NONE  = 3'd0,
        CF_LIM8  = 3'd1,
        CF_LIM10 = 3'd2,
        CF_LIM12 = 3'd3,
        CF_PROG  = 3'd7
    } clamp_fmt_e;

    typedef struct packed {
        logic       en;
        logic [2:0] fmt;
    } clamp_cfg_t;

    // Lower limit of an n-bit limited range, placed on a cw-bit scale.
    function automatic logic [31:0] lim_lo(input int n, input int cw);
        return (32'd16 << (n - 8)) << (cw - n);
    endfunction

    // Upper limit of an n-bit limited range on a cw-bit scale, low bits filled.
    function automatic logic [31:0] lim_hi(input int n, input int cw);
        return ((32'd235 << (n - 8)) << (cw - n)) | ((32'd1 << (cw - n)) - 32'd1);
    endfunction

endpackage

// File: rtl/clamp_bound_regs.sv
module clamp_bound_regs #(
    parameter int CW     = 12,
    parameter int NCH    = 3,
    parameter int CHW    = 2,
    parameter logic [CW-1:0] LO_DEF = 'h010,
    parameter logic [CW-1:0] HI_DEF = 'hFEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  logic [CHW-1:0]          ch,
    input  logic [CW-1:0]           lo,
    input  logic [CW-1:0]           hi,
    output logic [NCH-1:0][CW-1:0]  lo_q,
    output logic [NCH-1:0][CW-1:0]  hi_q
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[c] <= LO_DEF;
                hi_q[c] <= HI_DEF;
            end else if (wr && (ch == CHW'(c))) begin
                lo_q[c] <= lo;
                hi_q[c] <= hi;
            end
        end
    end

endmodule

// File: rtl/clamp_limit_sel.sv
module clamp_limit_sel
    import rng_clamp_pkg::*;
#(
    parameter int CW  = 12,
    parameter int NCH = 3
) (
    input  clamp_cfg_t              cfg,
    input  logic [NCH-1:0][CW-1:0]  prog_lo,
    input  logic [NCH-1:0][CW-1:0]  prog_hi,
    output logic                    act,
    output logic [NCH-1:0][CW-1:0]  eff_lo,
    output logic [NCH-1:0][CW-1:0]  eff_hi
);

    localparam logic [31:0] L8_LO  = lim_lo(8, CW);
    localparam logic [31:0] L8_HI  = lim_hi(8, CW);
    localparam logic [31:0] L10_LO = lim_lo(10, CW);
    localparam logic [31:0] L10_HI = lim_hi(10, CW);
    localparam logic [31:0] L12_LO = lim_lo(12, CW);
    localparam logic [31:0] L12_HI = lim_hi(12, CW);

    always_comb begin
        act    = 1'b0;
        eff_lo = prog_lo;
        eff_hi = prog_hi;
        case (cfg.fmt)
            CF_LIM8: begin
                act = cfg.en;
                for (int c = 0; c < NCH; c++) begin
                    eff_lo[c] = L8_LO[CW-1:0];
                    eff_hi[c] = L8_HI[CW-1:0];
                end
            end
            CF_LIM10: begin
                act = cfg.en;
                for (int c = 0; c < NCH; c++) begin
                    eff_lo[c] = L10_LO[CW-1:0];
                    eff_hi[c] = L10_HI[CW-1:0];
                end
            end
            CF_LIM12: begin
                act = cfg.en;
                for (int c = 0; c < NCH; c++) begin
                    eff_lo[c] = L12_LO[CW-1:0];
                    eff_hi[c] = L12_HI[CW-1:0];
                end
            end
            CF_PROG: act = cfg.en;
            default: act = 1'b0;
        endcase
    end

endmodule

// File: rtl/clamp_lane.sv
module clamp_lane #(
    parameter int CW = 12
) (
    input  logic          act,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic [CW-1:0] y
);

    always_comb begin
        if (!act)        y = x;
        else if (x < lo) y = lo;
        else if (x > hi) y = hi;
        else             y = x;
    end

endmodule

// File: rtl/pix_range_clamp.sv
module pix_range_clamp
    import rng_clamp_pkg::*;
#(
    parameter int CW = COMP_W_DEF,
    parameter logic [CW-1:0] LO_DEF = 'h010,
    parameter logic [CW-1:0] HI_DEF = 'hFEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_en,
    input  logic [2:0]    cfg_fmt,
    input  logic          bnd_wr,
    input  logic [1:0]    bnd_ch,
    input  logic [CW-1:0] bnd_lo,
    input  logic [CW-1:0] bnd_hi,
    input  logic          in_valid,
    input  logic [CW-1:0] in_r,
    input  logic [CW-1:0] in_g,
    input  logic [CW-1:0] in_b,
    output logic          out_valid,
    output logic [CW-1:0] out_r,
    output logic [CW-1:0] out_g,
    output logic [CW-1:0] out_b
);

    localparam int NCH = 3;
    localparam int CHW = 2;

    clamp_cfg_t              cfg_q;
    logic [NCH-1:0][CW-1:0]  prog_lo, prog_hi, eff_lo, eff_hi;
    logic [NCH-1:0][CW-1:0]  pix_in, pix_cl, pix_q;
    logic                    act;
    logic                    vld_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= '{en: cfg_en, fmt: cfg_fmt};
    end

    clamp_bound_regs #(
        .CW(CW), .NCH(NCH), .CHW(CHW), .LO_DEF(LO_DEF), .HI_DEF(HI_DEF)
    ) u_bounds (
        .clk(clk), .rst(rst), .wr(bnd_wr), .ch(bnd_ch),
        .lo(bnd_lo), .hi(bnd_hi), .lo_q(prog_lo), .hi_q(prog_hi)
    );

    clamp_limit_sel #(.CW(CW), .NCH(NCH)) u_sel (
        .cfg(cfg_q), .prog_lo(prog_lo), .prog_hi(prog_hi),
        .act(act), .eff_lo(eff_lo), .eff_hi(eff_hi)
    );

    assign pix_in = {in_b, in_g, in_r};

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        clamp_lane #(.CW(CW)) u_lane (
            .act(act), .x(pix_in[c]), .lo(eff_lo[c]), .hi(eff_hi[c]), .y(pix_cl[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            pix_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) pix_q <= pix_cl;
        end
    end

    assign out_valid = vld_q;
    assign out_r     = pix_q[0];
    assign out_g     = pix_q[1];
    assign out_b     = pix_q[2];

endmodule

// File: rtl/pix_range_clamp_chk.sv
module pix_range_clamp_chk
    import rng_clamp_pkg::*;
#(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          en_q,
    input logic [2:0]    fmt_q,
    input logic          in_valid,
    input logic [CW-1:0] in_r,
    input logic [CW-1:0] in_g,
    input logic [CW-1:0] in_b,
    input logic          out_valid,
    input logic [CW-1:0] out_r,
    input logic [CW-1:0] out_g,
    input logic [CW-1:0] out_b
);

    localparam logic [31:0] F12_LO = lim_lo(12, CW);
    localparam logic [31:0] F12_HI = lim_hi(12, CW);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R8
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

    // R2
    pass_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !en_q) |=>
        (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));

    // R4
    lim12_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && en_q && fmt_q == 3'd3) |=>
        (out_r >= F12_LO[CW-1:0] && out_r <= F12_HI[CW-1:0] &&
         out_g >= F12_LO[CW-1:0] && out_g <= F12_HI[CW-1:0] &&
         out_b >= F12_LO[CW-1:0] && out_b <= F12_HI[CW-1:0]));

endmodule

bind pix_range_clamp pix_range_clamp_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .en_q(cfg_q.en), .fmt_q(cfg_q.fmt),
    .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/pix_range_clamp_test.sv
module pix_range_clamp_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int NV = 10;

    // {en, fmt, r, g, b, exp_r, exp_g, exp_b}
    localparam logic [75:0] VEC [NV] = '{
        {1'b0, 3'd3, 12'd0,    12'd4095, 12'd100,  12'd0,    12'd4095, 12'd100},
        {1'b1, 3'd0, 12'd0,    12'd4095, 12'd5,    12'd0,    12'd4095, 12'd5},
        {1'b1, 3'd5, 12'd1,    12'd4095, 12'd3,    12'd1,    12'd4095, 12'd3},
        {1'b1, 3'd1, 12'd0,    12'd4095, 12'd2000, 12'd256,  12'd3775, 12'd2000},
        {1'b1, 3'd2, 12'd255,  12'd3764, 12'd3763, 12'd256,  12'd3763, 12'd3763},
        {1'b1, 3'd3, 12'd256,  12'd3761, 12'd10,   12'd256,  12'd3760, 12'd256},
        {1'b1, 3'd7, 12'd15,   12'd16,   12'd4080, 12'd16,   12'd16,   12'd4079},
        {1'b1, 3'd1, 12'd3776, 12'd3775, 12'd255,  12'd3775, 12'd3775, 12'd256},
        {1'b1, 3'd6, 12'd1,    12'd2,    12'd4095, 12'd1,    12'd2,    12'd4095},
        {1'b1, 3'd4, 12'd4095, 12'd0,    12'd7,    12'd4095, 12'd0,    12'd7}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0, cfg_en = 1'b0;
    logic [2:0]    cfg_fmt = '0;
    logic          bnd_wr = 1'b0;
    logic [1:0]    bnd_ch = '0;
    logic [CW-1:0] bnd_lo = '0, bnd_hi = '0;
    logic          in_valid = 1'b0;
    logic [CW-1:0] in_r = '0, in_g = '0, in_b = '0;
    logic          out_valid;
    logic [CW-1:0] out_r, out_g, out_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_range_clamp uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_fmt(cfg_fmt),
        .bnd_wr(bnd_wr), .bnd_ch(bnd_ch), .bnd_lo(bnd_lo), .bnd_hi(bnd_hi),
        .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check_px(input string tag, input logic vexp,
                            input logic [CW-1:0] er, eg, eb);
        total++;
        if (out_valid !== vexp || out_r !== er || out_g !== eg || out_b !== eb) begin
            bad++;
            $display("FAIL %s: got v=%0b %0d %0d %0d exp v=%0b %0d %0d %0d",
                     tag, out_valid, out_r, out_g, out_b, vexp, er, eg, eb);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [2:0] fmt);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = en; cfg_fmt = fmt;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic write_bnd(input logic [1:0] ch, input logic [CW-1:0] lo, hi);
        @(negedge clk);
        bnd_wr = 1'b1; bnd_ch = ch; bnd_lo = lo; bnd_hi = hi;
        @(negedge clk);
        bnd_wr = 1'b0;
    endtask

    task automatic send_pix(input logic [CW-1:0] r, g, b);
        @(negedge clk);
        in_valid = 1'b1; in_r = r; in_g = g; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_px("R1 reset", 1'b0, 12'd0, 12'd0, 12'd0);
        rst = 1'b0;

        // R1: cleared enable means pass-through
        send_pix(12'd0, 12'd4095, 12'd9);
        check_px("R1 cfg cleared", 1'b1, 12'd0, 12'd4095, 12'd9);

        for (int i = 0; i < NV; i++) begin
            string tag;
            logic [75:0] v;
            v = VEC[i];
            if (!v[75])                                      tag = "R2 vec";
            else if (v[74:72] == 3'd7)                       tag = "R5 vec";
            else if (v[74:72] >= 3'd1 && v[74:72] <= 3'd3)   tag = "R4 vec";
            else                                             tag = "R3 vec";
            write_cfg(v[75], v[74:72]);
            send_pix(v[71:60], v[59:48], v[47:36]);
            check_px(tag, 1'b1, v[35:24], v[23:12], v[11:0]);
        end

        // R6: per-channel bound writes, channel 3 ignored
        write_bnd(2'd0, 12'd100, 12'd200);
        write_bnd(2'd1, 12'd300, 12'd400);
        write_bnd(2'd2, 12'd500, 12'd600);
        write_bnd(2'd3, 12'd0,   12'd4095);
        write_cfg(1'b1, 3'd7);
        send_pix(12'd50, 12'd350, 12'd700);
        check_px("R6 bounds low", 1'b1, 12'd100, 12'd350, 12'd600);
        send_pix(12'd250, 12'd250, 12'd550);
        check_px("R6 bounds high", 1'b1, 12'd200, 12'd300, 12'd550);

        // R7: inverted bounds, lower test first
        write_bnd(2'd0, 12'd300, 12'd200);
        send_pix(12'd250, 12'd400, 12'd600);
        check_px("R7 inverted below", 1'b1, 12'd300, 12'd400, 12'd600);
        send_pix(12'd350, 12'd401, 12'd499);
        check_px("R7 inverted above", 1'b1, 12'd200, 12'd400, 12'd500);

        // R8: hold while idle and valid drops
        @(negedge clk);
        in_r = 12'd7; in_g = 12'd7; in_b = 12'd7;
        check_px("R8 idle hold", 1'b0, 12'd200, 12'd400, 12'd500);

        // R9: same-edge config write uses old setting
        write_cfg(1'b0, 3'd0);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = 1'b1; cfg_fmt = 3'd3;
        in_valid = 1'b1; in_r = 12'd4095; in_g = 12'd0; in_b = 12'd4095;
        @(negedge clk);
        cfg_wr = 1'b0; in_valid = 1'b0;
        check_px("R9 same edge", 1'b1, 12'd4095, 12'd0, 12'd4095);
        send_pix(12'd4095, 12'd0, 12'd4095);
        check_px("R9 next pixel", 1'b1, 12'd3760, 12'd256, 12'd3760);

        // R1: reset mid-run restores bound defaults and clears config
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_px("R1 reset again", 1'b0, 12'd0, 12'd0, 12'd0);
        rst = 1'b0;
        send_pix(12'd4095, 12'd1, 12'd2);
        check_px("R1 pass after reset", 1'b1, 12'd4095, 12'd1, 12'd2);
        write_cfg(1'b1, 3'd7);
        send_pix(12'd15, 12'd4095, 12'd1000);
        check_px("R1 default bounds", 1'b1, 12'd16, 12'd4079, 12'd1000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule